// File: doc/BRIEF.md
# Eight-Channel PWM DAC Bank

This block drives eight pulse-width-modulated pins that serve as cheap digital-to-analog converters once an external RC network smooths them, for settings such as volume, balance or brightness. The lower four channels have 7-bit resolution and the upper four have 6-bit resolution. A shared divide-by-three prescaler sets the PWM time unit, and one free-running counter supplies the phase for every channel.

Each channel compares the counter against a value that a small write port loads. The value is staged and takes effect only when that channel's period begins again, so a new setting never cuts a pulse short. The 7-bit group and the 6-bit group each have their own output-inversion bit. Each pin is shared with a general-purpose I/O line: a per-channel enable hands the pin to the PWM generator, and otherwise the pin carries the GPIO output value and output-enable. The pin's input value is always passed back.

Top module: `pwm_dac_bank`

## Requirements
- R1: Channels 0 to 3 have a period of 128 time units and channels 4 to 7 a period of 64 time units.
- R2: One time unit is three clock cycles; the shared phase counter advances once every three clocks and holds otherwise.
- R3: Channel i's value is written at address 10+i; the pin is HIGH (non-inverted) for value × time unit per period; channels 4 to 7 keep only bits 5:0 of the written byte.
- R4: A value of 0 gives a constant LOW output; the maximum value (127 or 63) gives HIGH for all but one time unit of the period.
- R5: A written value takes effect only at the start of the channel's next period.
- R6: Address 20 holds polarity: bit 0 inverts channels 0 to 3, bit 1 inverts channels 4 to 7, and neither bit affects the other group.
- R7: Address 21 holds the enables, bit i for channel i; an enabled pin drives the PWM level with padOe high, a disabled pin drives gpioOut[i] with padOe equal to gpioOe[i].
- R8: gpioIn always equals padIn, whether or not the channel is enabled.
- R9: Reset clears all values, polarity and enable bits, so every pin starts as a GPIO line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register write address |
| wrData | input | 8 | Register write data |
| gpioOut | input | 8 | GPIO output values for disabled pins |
| gpioOe | input | 8 | GPIO output enables for disabled pins |
| padIn | input | 8 | Sampled pin levels |
| padOut | output | 8 | Pin output levels |
| padOe | output | 8 | Pin output enables |
| gpioIn | output | 8 | Pin levels returned to the GPIO logic |

## Verification
The bench measures HIGH time over a full 384-cycle window, so a prescaler that divides by two or four, a comparator using <= instead of <, or a 6-bit channel that keeps bit 6 of the written byte all shift the count away from value × 3 per period. The deferred-update test writes a new value just after a period begins; a design that loads the value at once shortens that pulse from 192 to 30 cycles. The polarity vectors set only the other group's bit as well as the channel's own, catching a swapped or shared polarity bit, and the value 0 and maximum cases catch off-by-one comparisons at both ends.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
  localparam int NUM_CH = 8;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              tick;
    logic              periodHi;
    logic              periodLo;
    logic [NUM_CH-1:0] wrLatch;
    logic              wrPol;
    logic              wrEnable;
  } ctlStrobes_t;
endpackage

// File: rtl/pwm_ctl.sv
module pwm_ctl
  import pwm_dac_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int PRESCALE   = 3,
  parameter int HI_BITS    = 7,
  parameter int LO_BITS    = 6,
  parameter int LATCH_BASE = 10,
  parameter int POL_ADDR   = 20,
  parameter int EN_ADDR    = 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  output ctlStrobes_t        strobe,
  output logic [HI_BITS-1:0] cnt
);
  localparam int PRE_W = $clog2(PRESCALE);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] preCnt;
  logic             tick;

  assign tick = (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preCnt <= '0;
      cnt    <= '0;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick) cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    strobe.tick     = tick;
    strobe.periodHi = tick && (cnt == '1);
    strobe.periodLo = tick && (cnt[LO_BITS-1:0] == '1);
    strobe.wrPol    = wrEn && (wrAddr == ADDR_W'(POL_ADDR));
    strobe.wrEnable = wrEn && (wrAddr == ADDR_W'(EN_ADDR));
    for (int i = 0; i < NUM_CH; i++)
      strobe.wrLatch[i] = wrEn && (wrAddr == ADDR_W'(LATCH_BASE + i));
  end
endmodule

// File: rtl/pwm_dp.sv
module pwm_dp
  import pwm_dac_pkg::*;
#(
  parameter int NUM_HI  = 4,
  parameter int HI_BITS = 7,
  parameter int LO_BITS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobes_t        strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [HI_BITS-1:0] cnt,
  input  logic [NUM_CH-1:0]  gpioOut,
  input  logic [NUM_CH-1:0]  gpioOe,
  output logic [NUM_CH-1:0]  padOut,
  output logic [NUM_CH-1:0]  padOe,
  output logic [NUM_CH-1:0]  enBits,
  output logic [1:0]         polBits,
  output logic [NUM_CH-1:0]  zeroActive
);
  localparam int PAD_BITS = HI_BITS - LO_BITS;

  logic [HI_BITS-1:0] shadow [NUM_CH];
  logic [HI_BITS-1:0] active [NUM_CH];
  logic [NUM_CH-1:0]  pwmLvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enBits  <= '0;
      polBits <= '0;
    end else begin
      if (strobe.wrEnable) enBits  <= wrData[NUM_CH-1:0];
      if (strobe.wrPol)    polBits <= wrData[1:0];
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic reload, raw, pol;
    logic [HI_BITS-1:0] wrVal;

    if (i < NUM_HI) begin : g_hi
      assign reload = strobe.periodHi;
      assign wrVal  = wrData[HI_BITS-1:0];
      assign raw    = cnt < active[i];
      assign pol    = polBits[0];
    end else begin : g_lo
      assign reload = strobe.periodLo;
      assign wrVal  = {{PAD_BITS{1'b0}}, wrData[LO_BITS-1:0]};
      assign raw    = cnt[LO_BITS-1:0] < active[i][LO_BITS-1:0];
      assign pol    = polBits[1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow[i] <= '0;
        active[i] <= '0;
      end else begin
        if (strobe.wrLatch[i]) shadow[i] <= wrVal;
        if (reload)            active[i] <= shadow[i];
      end
    end

    assign pwmLvl[i]     = raw ^ pol;
    assign zeroActive[i] = (active[i] == '0);
    assign padOut[i]     = enBits[i] ? pwmLvl[i] : gpioOut[i];
    assign padOe[i]      = enBits[i] ? 1'b1 : gpioOe[i];
  end
endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank
  import pwm_dac_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int NUM_HI     = 4,
  parameter int HI_BITS    = 7,
  parameter int LO_BITS    = 6,
  parameter int PRESCALE   = 3,
  parameter int LATCH_BASE = 10,
  parameter int POL_ADDR   = 20,
  parameter int EN_ADDR    = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CH-1:0] gpioOut,
  input  logic [NUM_CH-1:0] gpioOe,
  input  logic [NUM_CH-1:0] padIn,
  output logic [NUM_CH-1:0] padOut,
  output logic [NUM_CH-1:0] padOe,
  output logic [NUM_CH-1:0] gpioIn
);
  ctlStrobes_t        strobe;
  logic [HI_BITS-1:0] cnt;
  logic [NUM_CH-1:0]  enBits;
  logic [1:0]         polBits;
  logic [NUM_CH-1:0]  zeroActive;

  pwm_ctl #(
    .ADDR_W(ADDR_W), .PRESCALE(PRESCALE), .HI_BITS(HI_BITS), .LO_BITS(LO_BITS),
    .LATCH_BASE(LATCH_BASE), .POL_ADDR(POL_ADDR), .EN_ADDR(EN_ADDR)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .strobe(strobe), .cnt(cnt)
  );

  pwm_dp #(.NUM_HI(NUM_HI), .HI_BITS(HI_BITS), .LO_BITS(LO_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(wrData), .cnt(cnt),
    .gpioOut(gpioOut), .gpioOe(gpioOe), .padOut(padOut), .padOe(padOe),
    .enBits(enBits), .polBits(polBits), .zeroActive(zeroActive)
  );

  assign gpioIn = padIn;
endmodule

// File: rtl/pwm_dac_bank_chk.sv
module pwm_dac_bank_chk
  import pwm_dac_pkg::*;
#(
  parameter int HI_BITS = 7,
  parameter int NUM_HI  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic [HI_BITS-1:0] cnt,
  input logic [NUM_CH-1:0]  enBits,
  input logic [1:0]         polBits,
  input logic [NUM_CH-1:0]  zeroActive,
  input logic [NUM_CH-1:0]  gpioOut,
  input logic [NUM_CH-1:0]  gpioOe,
  input logic [NUM_CH-1:0]  padOut,
  input logic [NUM_CH-1:0]  padOe
);
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick ##1 !tick);

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_gpio_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (((padOut ^ gpioOut) | (padOe ^ gpioOe)) & ~enBits) == '0);

  assert_pwm_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (padOe & enBits) == enBits);

  assert_zero_low_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (zeroActive[0] && enBits[0] && !polBits[0]) |-> !padOut[0]);

  assert_zero_low_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (zeroActive[NUM_HI] && enBits[NUM_HI] && !polBits[1]) |-> !padOut[NUM_HI]);

  assert_deferred_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(zeroActive[0]) |-> (cnt == '0));
endmodule

bind pwm_dac_bank pwm_dac_bank_chk #(.HI_BITS(HI_BITS), .NUM_HI(NUM_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(strobe.tick), .cnt(cnt), .enBits(enBits),
  .polBits(polBits), .zeroActive(zeroActive), .gpioOut(gpioOut), .gpioOe(gpioOe),
  .padOut(padOut), .padOe(padOe)
);

// File: tb/sim_pwm_dac_bank.sv
`timescale 1ns/1ps
module sim_pwm_dac_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] gpioOut = 8'h5A;
  logic [7:0] gpioOe = 8'hC3;
  logic [7:0] padIn = 8'h96;
  logic [7:0] padOut, padOe, gpioIn;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pwm_dac_bank u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .gpioOut(gpioOut), .gpioOe(gpioOe), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .gpioIn(gpioIn)
  );

  // channel, value written, polarity register, expected HIGH cycles in 384
  localparam int NVEC = 11;
  localparam int VEC [NVEC][4] = '{
    '{0,   0, 0,   0},   // R4 zero
    '{0, 127, 0, 381},   // R4 max 7-bit
    '{1,  64, 0, 192},   // R3
    '{3,   1, 0,   3},   // R3
    '{4,  32, 1, 192},   // R6 other-group bit
    '{7,  63, 0, 378},   // R4 max 6-bit
    '{5, 127, 0, 378},   // R3 bit 6 dropped
    '{2,  10, 1, 354},   // R6 inverted 7-bit
    '{6,   5, 2, 354},   // R6 inverted 6-bit
    '{6,   0, 2, 384},   // R6 R4 inverted zero
    '{1,  40, 2, 120}    // R6 other-group bit
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input int addr, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'(addr); wrData = 8'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic countHigh(input int ch, output int highs);
    highs = 0;
    for (int k = 0; k < 384; k++) begin
      @(negedge clk);
      if (padOut[ch]) highs++;
    end
  endtask

  initial begin
    int highs;
    int prevLvl;
    int found;
    logic [7:0] mask;

    // R9 reset state: pins follow GPIO
    repeat (4) @(negedge clk);
    check("R9 padOut in reset", int'(padOut), 8'h5A);
    check("R9 padOe in reset", int'(padOe), 8'hC3);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R9 padOut after reset", int'(padOut), 8'h5A);
    check("R9 padOe after reset", int'(padOe), 8'hC3);
    check("R8 gpioIn", int'(gpioIn), 8'h96);

    // R1 R3 R4 R6 R7 vector table
    for (int v = 0; v < NVEC; v++) begin
      mask = 8'(1 << VEC[v][0]);
      regWrite(10 + VEC[v][0], VEC[v][1]);
      regWrite(20, VEC[v][2]);
      regWrite(21, int'(mask));
      repeat (800) @(negedge clk);
      countHigh(VEC[v][0], highs);
      check($sformatf("R3 R1 vector %0d high cycles", v), highs, VEC[v][3]);
      check($sformatf("R7 vector %0d other pins", v),
            int'(padOut & ~mask), int'(gpioOut & ~mask));
      check($sformatf("R7 vector %0d padOe", v),
            int'(padOe), int'(gpioOe | mask));
    end

    // R2 R1: 6-bit channel period is 192 clocks, 7-bit 384 (single period window)
    regWrite(20, 0);
    regWrite(14, 32);
    regWrite(21, 8'h10);
    repeat (800) @(negedge clk);
    highs = 0;
    for (int k = 0; k < 192; k++) begin
      @(negedge clk);
      if (padOut[4]) highs++;
    end
    check("R1 R2 6-bit single period", highs, 96);

    // R5 deferred update: ch0 at 64, write 10 just after a period starts
    regWrite(10, 64);
    regWrite(21, 8'h01);
    repeat (800) @(negedge clk);
    found = 0;
    prevLvl = int'(padOut[0]);
    for (int k = 0; k < 1000 && found == 0; k++) begin
      @(negedge clk);
      if (prevLvl == 0 && padOut[0]) found = 1;
      else prevLvl = int'(padOut[0]);
    end
    check("R5 period start found", found, 1);
    highs = int'(padOut[0]);
    for (int k = 1; k < 384; k++) begin
      @(negedge clk);
      if (k == 5) begin wrEn = 1'b1; wrAddr = 5'd10; wrData = 8'd10; end
      if (k == 6) wrEn = 1'b0;
      if (padOut[0]) highs++;
    end
    check("R5 old value holds for current period", highs, 192);
    countHigh(0, highs);
    check("R5 new value after period start", highs, 30);

    // R8 gpioIn tracks padIn with a PWM pin enabled
    padIn = 8'h3C;
    @(negedge clk);
    check("R8 gpioIn while enabled", int'(gpioIn), 8'h3C);

    // R9 reset again clears enables and values
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    gpioOut = 8'hF0;
    gpioOe = 8'h0F;
    repeat (3) @(negedge clk);
    check("R9 padOut after re-reset", int'(padOut), 8'hF0);
    check("R9 padOe after re-reset", int'(padOe), 8'h0F);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule